// File: doc/BRIEF.md
# Serial shift-and-store output register

This block is a serial-in, parallel-out register. Bits come in on a serial data line and move one place along a chain of stages on each rising edge of a shift clock. A separate storage word copies the chain while a strobe is high and keeps its value while the strobe is low. The host can therefore shift a new word in without disturbing the word that is currently on show. The storage word drives the parallel outputs through a tri-state buffer that an output-enable input controls. For logic that cannot use high impedance, the same data is also given as a plain vector with an enable.

Two serial taps let several blocks be joined into one longer chain. The primary tap is the last stage itself, so it changes on the rising shift-clock edge. The secondary tap copies the last stage on the next falling edge and holds it through the following rising edge. When a downstream block takes its serial input from this tap, it has a full half period of hold margin.

The whole block runs on one system clock. The shift clock is sampled as a data input, and its rising and falling edges are found in logic. The storage word is a register that loads on every system clock while the strobe is high, one system cycle behind the chain.

Top module: `shift_store_reg`

## Requirements
- R1: A synchronous active-high reset clears every chain stage, the storage word and both serial taps to 0.
- R2: On each detected rising edge of `shift_clk`, stage 0 takes `ser_in` and each stage n takes the old value of stage n-1. When `ser_in` is 1 the new stage 0 is 1, and when it is 0 the new stage 0 is 0. Parallel bit n shows stage n.
- R3: While `strobe` is high, the storage word takes the chain contents on every system clock, one cycle behind the chain. While `strobe` is low, the storage word holds its value even while the chain shifts.
- R4: When `out_en` is 1, `par_oe` is 1 and `par_pins` equals the storage word. When `out_en` is 0, `par_oe` is 0 and all of `par_pins` are high impedance. `par_data` always shows the storage word.
- R5: `out_en` low stops neither shifting nor storing. A word shifted and strobed in while the outputs are disabled appears as soon as they are enabled.
- R6: `ser_out` equals the last chain stage, so it changes only on a rising shift-clock edge and takes the bit that was in the second-to-last stage.
- R7: `ser_late` loads the last stage on each falling `shift_clk` edge and holds that value at all other times, including through the next rising edge.
- R8: A falling `shift_clk` edge leaves the chain, and therefore `ser_out`, unchanged.
- R9: When two blocks are joined through `ser_late`, 16 shifted bits sent most significant first, followed by one strobe pulse, leave the first 8 bits sent in the downstream block and the last 8 in the upstream block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data input |
| shift_clk | input | 1 | Shift clock, sampled on `clk` |
| strobe | input | 1 | Storage load enable, level sensitive |
| out_en | input | 1 | Parallel output enable |
| par_data | output | STAGES | Storage word as plain data |
| par_oe | output | 1 | Drive enable for the parallel outputs |
| par_pins | output | STAGES | Tri-state parallel outputs |
| ser_out | output | 1 | Primary cascade tap, rising edge |
| ser_late | output | 1 | Secondary cascade tap, falling edge |

## Verification
The chain is fed an asymmetric byte one bit at a time with the strobe high. Checks after every rising and every falling edge separate a correct shift direction from a reversed one, and a tap that moves on the wrong edge from one that moves on the right edge. A second run shifts with the strobe low, then pulses it. This separates a storage word that holds from one that follows the chain. A third run shifts and strobes with the outputs disabled, which catches an enable that also gates storage. A 16-bit pattern with distinct halves, sent through two cascaded blocks, exposes an off-by-one or a swapped word in the cascade path.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int unsigned DEF_STAGES = 8;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_edge_t;

    function automatic sclk_edge_t find_edges(input logic now_v, input logic prev_v);
        sclk_edge_t e;
        e.rise = now_v & ~prev_v;
        e.fall = ~now_v & prev_v;
        return e;
    endfunction
endpackage

// File: rtl/ssr_edge_detect.sv
module ssr_edge_detect
    import ssr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    output sclk_edge_t edges
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign edges = find_edges(sclk, sclk_q);
endmodule

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              din,
    output logic [STAGES-1:0] stages
);
    for (genvar n = 0; n < STAGES; n++) begin : g_stage
        logic src;
        if (n == 0) begin : g_head
            assign src = din;
        end else begin : g_body
            assign src = stages[n-1];
        end
        always_ff @(posedge clk) begin
            if (rst)          stages[n] <= 1'b0;
            else if (advance) stages[n] <= src;
        end
    end
endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAGES-1:0] din,
    output logic [STAGES-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/ssr_cascade.sv
module ssr_cascade
    import ssr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sclk_edge_t edges,
    input  logic       last,
    output logic       ser_out,
    output logic       ser_late
);
    assign ser_out = last;

    always_ff @(posedge clk) begin
        if (rst)             ser_late <= 1'b0;
        else if (edges.fall) ser_late <= last;
    end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg
    import ssr_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              shift_clk,
    input  logic              strobe,
    input  logic              out_en,
    output logic [STAGES-1:0] par_data,
    output logic              par_oe,
    output logic [STAGES-1:0] par_pins,
    output logic              ser_out,
    output logic              ser_late
);
    localparam int unsigned LAST = STAGES - 1;

    sclk_edge_t        edges;
    logic [STAGES-1:0] chain;
    logic [STAGES-1:0] stored;

    ssr_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .sclk  (shift_clk),
        .edges (edges)
    );

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .advance (edges.rise),
        .din     (ser_in),
        .stages  (chain)
    );

    ssr_store #(.STAGES(STAGES)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (strobe),
        .din  (chain),
        .q    (stored)
    );

    ssr_cascade u_casc (
        .clk      (clk),
        .rst      (rst),
        .edges    (edges),
        .last     (chain[LAST]),
        .ser_out  (ser_out),
        .ser_late (ser_late)
    );

    assign par_data = stored;
    assign par_oe   = out_en;
    assign par_pins = out_en ? stored : {STAGES{1'bz}};
endmodule

// File: rtl/shift_store_reg_chk.sv
module shift_store_reg_chk #(
    parameter int unsigned STAGES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              shift_clk,
    input logic              strobe,
    input logic [STAGES-1:0] par_data,
    input logic              par_oe,
    input logic [STAGES-1:0] par_pins,
    input logic              ser_out,
    input logic              ser_late
);
    logic prev_sclk;
    logic fall_seen;

    always_ff @(posedge clk) begin
        if (rst) prev_sclk <= 1'b0;
        else     prev_sclk <= shift_clk;
    end

    assign fall_seen = prev_sclk & ~shift_clk;

    assert_store_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(par_data));

    assert_pins_match_R4: assert property (@(posedge clk) disable iff (rst)
        par_oe |-> (par_pins == par_data));

    assert_late_capture_R7: assert property (@(posedge clk) disable iff (rst)
        fall_seen |=> (ser_late == $past(ser_out)));

    assert_late_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !fall_seen |=> $stable(ser_late));

    assert_fall_stable_R8: assert property (@(posedge clk) disable iff (rst)
        fall_seen |=> $stable(ser_out));
endmodule

bind shift_store_reg shift_store_reg_chk #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_clk (shift_clk),
    .strobe    (strobe),
    .par_data  (par_data),
    .par_oe    (par_oe),
    .par_pins  (par_pins),
    .ser_out   (ser_out),
    .ser_late  (ser_late)
);

// File: tb/sim_shift_store_reg.sv
`timescale 1ns/1ps
module sim_shift_store_reg;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0, shift_clk = 1'b0, strobe = 1'b0, out_en = 1'b0;
    logic [7:0] pd0, pd1, pp0, pp1;
    logic oe0, oe1, so0, so1, sl0, sl1;

    always #10 clk = ~clk;

    shift_store_reg u0 (.clk(clk), .rst(rst), .ser_in(ser_in), .shift_clk(shift_clk),
        .strobe(strobe), .out_en(out_en), .par_data(pd0), .par_oe(oe0), .par_pins(pp0),
        .ser_out(so0), .ser_late(sl0));
    shift_store_reg u1 (.clk(clk), .rst(rst), .ser_in(sl0), .shift_clk(shift_clk),
        .strobe(strobe), .out_en(out_en), .par_data(pd1), .par_oe(oe1), .par_pins(pp1),
        .ser_out(so1), .ser_late(sl1));

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    event  check_now;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    logic [7:0] m0, m1, st0, st1;
    logic       late0;

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            0: return pd0;
            1: return pd1;
            2: return pp0;
            3: return {7'd0, so0};
            4: return {7'd0, sl0};
            5: return {7'd0, oe0};
            default: return 8'hxx;
        endcase
    endfunction

    initial begin : monitor
        forever begin
            @(check_now);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input string req, input int sel, input logic [7:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic flush();
        -> check_now;
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m0 = '0; m1 = '0; st0 = '0; st1 = '0; late0 = 1'b0;
        @(negedge clk);
    endtask

    task automatic shift_bit(input logic b, input bit chk);
        logic old_late;
        old_late  = late0;
        ser_in    = b;
        shift_clk = 1'b1;
        m1 = {m1[6:0], late0};
        m0 = {m0[6:0], b};
        repeat (3) @(negedge clk);
        if (strobe) begin st0 = m0; st1 = m1; end
        if (chk) begin
            expect_val("R2/R3 parallel after rise", 0, st0);
            expect_val("R6 ser_out after rise", 3, {7'd0, m0[7]});
            expect_val("R7 ser_late held through rise", 4, {7'd0, old_late});
            flush();
        end
        shift_clk = 1'b0;
        late0 = m0[7];
        repeat (3) @(negedge clk);
        if (chk) begin
            expect_val("R8 parallel unchanged at fall", 0, st0);
            expect_val("R8 ser_out unchanged at fall", 3, {7'd0, m0[7]});
            expect_val("R7 ser_late loads at fall", 4, {7'd0, late0});
            flush();
        end
    endtask

    task automatic strobe_pulse();
        strobe = 1'b1;
        repeat (2) @(negedge clk);
        st0 = m0; st1 = m1;
        strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0]  pat;
        logic [15:0] word16;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: dirty the state, then reset
        strobe = 1'b1; out_en = 1'b1;
        m0 = '0; m1 = '0; late0 = 1'b0;
        for (int i = 0; i < 8; i++) shift_bit(1'b1, 1'b0);
        strobe = 1'b0;
        do_reset();
        expect_val("R1 storage cleared", 0, 8'h00);
        expect_val("R1 downstream storage cleared", 1, 8'h00);
        expect_val("R1 ser_out cleared", 3, 8'h00);
        expect_val("R1 ser_late cleared", 4, 8'h00);
        flush();

        // R2 R6 R7 R8: shift an asymmetric byte with the strobe high
        strobe = 1'b1;
        pat = 8'b1011_0010;
        for (int i = 7; i >= 0; i--) shift_bit(pat[i], 1'b1);
        expect_val("R2 full byte in order", 0, pat);
        expect_val("R4 pins follow storage", 2, pat);
        expect_val("R4 drive enable on", 5, 8'h01);
        flush();

        // R3: shift with strobe low, storage must hold
        strobe = 1'b0;
        for (int i = 0; i < 4; i++) shift_bit(i[0], 1'b1);
        expect_val("R3 storage held while strobe low", 0, pat);
        flush();
        strobe_pulse();
        expect_val("R3 storage takes chain on strobe", 0, {pat[3:0], 4'b0101});
        flush();

        // R4 R5: disable outputs, keep shifting and storing
        out_en = 1'b0;
        @(negedge clk);
        expect_val("R4 drive enable off", 5, 8'h00);
        flush();
        for (int i = 0; i < 3; i++) shift_bit(1'b1, 1'b0);
        strobe_pulse();
        out_en = 1'b1;
        @(negedge clk);
        expect_val("R5 storage kept moving while disabled", 0, st0);
        expect_val("R5 pins show word after enable", 2, {pat[0], 4'b0101, 3'b111});
        flush();

        // R9: cascade of two through ser_late
        do_reset();
        word16 = 16'hA5C3;
        for (int i = 15; i >= 0; i--) shift_bit(word16[i], 1'b0);
        strobe_pulse();
        expect_val("R9 upstream word", 0, word16[7:0]);
        expect_val("R9 downstream word", 1, word16[15:8]);
        flush();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule